// File: doc/BRIEF.md
# Entropy Refresh and Timeout Controller

This controller sits beside a masked hash engine and decides when fresh randomness must be fetched from an external entropy source. It counts finished hash operations. When the count reaches a programmable threshold, or when software forces a refresh, it opens a request/acknowledge handshake with the source. A prescaled wait timer guards each outstanding request.

It also checks the configuration at the points where entropy matters. An illegal entropy mode is caught when a fetch is triggered. An operation that starts in external-source mode without the ready configuration bit set is flagged. A request that stays unanswered past the programmed limit is reported as a timeout. Each error produces a one-cycle pulse and a held error code. The controller stays in the error state until the error is acknowledged, and normal operation then resumes.

Top module: `entropy_refresh_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `src_req_o`, `seed_valid_o`, `err_pulse_o`, `err_code_o` and `hash_cnt_o` are all zero.
- R2: With masking on, each `op_done_i` pulse adds one to the hash count on the following edge. The count saturates at its maximum (255 by default) and does not wrap. A threshold of zero never triggers a refresh.
- R3: When a completed operation brings the count to a non-zero threshold or beyond, the count returns to zero on that edge. In external-source mode with the controller idle, `src_req_o` rises on that same edge.
- R4: A `sw_req_i` pulse forces a fetch exactly as a threshold hit does. A `sw_clr_i` pulse zeroes the count and takes priority over a simultaneous `op_done_i`.
- R5: With masking off, `hash_cnt_o` reads zero, the count is held at zero, and no trigger raises `src_req_o`.
- R6: `src_req_o` stays high until `src_ack_i` is sampled high. On that edge `seed_o` captures `src_data_i`, `seed_valid_o` pulses for exactly one cycle and `src_req_o` drops.
- R7: With prescale value P and wait limit L (L non-zero), the prescaler ticks every P+1 cycles. An unanswered request stays high for L*(P+1)+1 cycles. After that, `err_code_o` becomes 1 (timeout) and `src_req_o` drops. A limit of zero disables the timeout.
- R8: The timeout error never fires while the mode is not external-source (`mode_i` = 2'b10) or while masking is off.
- R9: A trigger while the mode is neither software (2'b01) nor external-source (2'b10) sets `err_code_o` to 2 and raises no request.
- R10: When `op_start_i` arrives while idle, with masking on, the mode external-source and `ready_cfg_i` low, `err_code_o` becomes 3. In every other combination, `op_start_i` raises no error.
- R11: On entry to the error state `err_pulse_o` is high for one cycle and `err_code_o` holds. Triggers are ignored while in the error state. An `err_processed_i` pulse returns the controller to idle with `err_code_o` at 0.
- R12: In software mode (2'b01) a trigger raises neither a request nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_en_i | input | 1 | Masking enabled |
| mode_i | input | 2 | Entropy mode: 01 software, 10 external source, others illegal |
| ready_cfg_i | input | 1 | Entropy-ready configuration bit |
| threshold_i | input | CNT_W | Refresh threshold in completed operations, 0 disables |
| prescale_i | input | PRE_W | Prescaler terminal value P |
| wait_limit_i | input | WAIT_W | Timeout limit in prescaler ticks, 0 disables |
| op_start_i | input | 1 | Hash operation start pulse |
| op_done_i | input | 1 | Hash operation completion pulse |
| sw_req_i | input | 1 | Software command: force an entropy fetch |
| sw_clr_i | input | 1 | Software command: clear the hash count |
| err_processed_i | input | 1 | Error acknowledged, return to idle |
| src_req_o | output | 1 | Request to the entropy source |
| src_ack_i | input | 1 | Acknowledge from the entropy source |
| src_data_i | input | DATA_W | Entropy word from the source |
| seed_o | output | DATA_W | Last captured entropy word |
| seed_valid_o | output | 1 | One-cycle pulse when seed_o is updated |
| hash_cnt_o | output | CNT_W | Completed-operation count (0 when unmasked) |
| err_code_o | output | 2 | 0 none, 1 timeout, 2 illegal mode, 3 ready bit missing |
| err_pulse_o | output | 1 | One-cycle pulse on entering the error state |

## Verification
A corrupted hash count shows up on `hash_cnt_o` at the very next edge. It also shows as a request that rises one operation early or late, so the bench compares the count every cycle against its own model. A prescaler or wait counter that is off by even one step moves the timeout edge. The bench therefore checks `src_req_o` and `err_code_o` on every cycle of a timeout window rather than only at its end. A controller stuck in the wrong state shows within one cycle as a request that is missing or extra, or as an error pulse that does not return to zero.

// File: rtl/entref_pkg.sv
// Shared encodings for the entropy refresh controller.
// Assumes a 2-bit mode field and a 2-bit error code seen at the ports.
package entref_pkg;
    typedef enum logic [1:0] {
        MODE_SW  = 2'b01,
        MODE_EXT = 2'b10
    } ent_mode_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_TIMEOUT  = 2'd1,
        ERR_BAD_MODE = 2'd2,
        ERR_NO_READY = 2'd3
    } ent_err_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ERR  = 2'd2
    } ent_state_e;
endpackage

// File: rtl/entref_hash_counter.sv
// Counts completed hash operations and flags a refresh when the count
// reaches a non-zero threshold. Saturates at all-ones. Held at zero
// while masking is off. Assumes op_done_i is a single-cycle pulse.
module entref_hash_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_en_i,
    input  logic             op_done_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] threshold_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    // Wide increment and threshold comparison for this operation.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        hit_o   = mask_en_i && op_done_i && !clr_i && (threshold_i != '0)
                  && (cnt_inc >= {1'b0, threshold_i});
    end

    // Count register: clear, refresh restart, or saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n || !mask_en_i || clr_i || hit_o) begin
            cnt_q <= '0;
        end else if (op_done_i && cnt_q != CntMax) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    assign cnt_o = mask_en_i ? cnt_q : '0;
endmodule

// File: rtl/entref_wait_timer.sv
// Prescaled timeout timer. While run_i is high the prescaler counts
// 0..prescale_i and each wrap is one tick. Ticks are counted up to
// limit_i, where the count stops and expired_o stays high. A limit of
// zero never expires. Both counters clear when run_i is low.
module entref_wait_timer #(
    parameter int PRE_W  = 8,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [PRE_W-1:0]  prescale_i,
    input  logic [WAIT_W-1:0] limit_i,
    output logic              expired_o
);
    logic [PRE_W-1:0]  pre_q;
    logic [WAIT_W-1:0] wait_q;
    logic              tick;

    // Tick when the prescaler reaches its terminal value.
    always_comb tick = (pre_q == prescale_i);

    // Prescaler register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick) pre_q <= '0;
        else                          pre_q <= pre_q + 1'b1;
    end

    // Tick counter that stops at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)                 wait_q <= '0;
        else if (tick && wait_q != limit_i)   wait_q <= wait_q + 1'b1;
    end

    assign expired_o = run_i && (limit_i != '0) && (wait_q == limit_i);
endmodule

// File: rtl/entropy_refresh_ctrl.sv
// Entropy refresh and timeout controller. Collects refresh triggers
// (threshold hit or software command), checks the mode, runs the
// source handshake under a timeout and reports errors until they are
// acknowledged. Assumes all command inputs are single-cycle pulses.
module entropy_refresh_ctrl
    import entref_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 8,
    parameter int WAIT_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_en_i,
    input  logic [1:0]        mode_i,
    input  logic              ready_cfg_i,
    input  logic [CNT_W-1:0]  threshold_i,
    input  logic [PRE_W-1:0]  prescale_i,
    input  logic [WAIT_W-1:0] wait_limit_i,
    input  logic              op_start_i,
    input  logic              op_done_i,
    input  logic              sw_req_i,
    input  logic              sw_clr_i,
    input  logic              err_processed_i,
    output logic              src_req_o,
    input  logic              src_ack_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [DATA_W-1:0] seed_o,
    output logic              seed_valid_o,
    output logic [CNT_W-1:0]  hash_cnt_o,
    output logic [1:0]        err_code_o,
    output logic              err_pulse_o
);
    ent_state_e state_q;
    ent_err_e   err_q;
    logic       hit, expired, trigger, mode_ext, mode_sw, missing_ready;

    entref_hash_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_en_i   (mask_en_i),
        .op_done_i   (op_done_i),
        .clr_i       (sw_clr_i),
        .threshold_i (threshold_i),
        .cnt_o       (hash_cnt_o),
        .hit_o       (hit)
    );

    entref_wait_timer #(.PRE_W(PRE_W), .WAIT_W(WAIT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (state_q == ST_WAIT),
        .prescale_i (prescale_i),
        .limit_i    (wait_limit_i),
        .expired_o  (expired)
    );

    // Decode mode and fetch conditions.
    always_comb begin
        mode_ext      = (mode_i == MODE_EXT);
        mode_sw       = (mode_i == MODE_SW);
        trigger       = mask_en_i && (sw_req_i || hit);
        missing_ready = op_start_i && mask_en_i && mode_ext && !ready_cfg_i;
    end

    // Control state, error code and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            err_q       <= ERR_NONE;
            err_pulse_o <= 1'b0;
        end else begin
            err_pulse_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (missing_ready) begin
                        state_q     <= ST_ERR;
                        err_q       <= ERR_NO_READY;
                        err_pulse_o <= 1'b1;
                    end else if (trigger && !mode_ext && !mode_sw) begin
                        state_q     <= ST_ERR;
                        err_q       <= ERR_BAD_MODE;
                        err_pulse_o <= 1'b1;
                    end else if (trigger && mode_ext) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (src_ack_i) begin
                        state_q <= ST_IDLE;
                    end else if (expired && mask_en_i && mode_ext) begin
                        state_q     <= ST_ERR;
                        err_q       <= ERR_TIMEOUT;
                        err_pulse_o <= 1'b1;
                    end
                end
                default: begin
                    if (err_processed_i) begin
                        state_q <= ST_IDLE;
                        err_q   <= ERR_NONE;
                    end
                end
            endcase
        end
    end

    // Capture the entropy word on a completed handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_o       <= '0;
            seed_valid_o <= 1'b0;
        end else begin
            seed_valid_o <= (state_q == ST_WAIT) && src_ack_i;
            if ((state_q == ST_WAIT) && src_ack_i) seed_o <= src_data_i;
        end
    end

    assign src_req_o  = (state_q == ST_WAIT);
    assign err_code_o = err_q;
endmodule

// File: rtl/entropy_refresh_ctrl_checker.sv
// Port-level properties of the entropy refresh controller, bound to
// every instance of the top module.
module entropy_refresh_ctrl_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mask_en_i,
    input logic [1:0]       mode_i,
    input logic             op_done_i,
    input logic             sw_clr_i,
    input logic             err_processed_i,
    input logic             src_req_o,
    input logic             src_ack_i,
    input logic             seed_valid_o,
    input logic [CNT_W-1:0] hash_cnt_o,
    input logic [1:0]       err_code_o,
    input logic             err_pulse_o
);
    // R6: an accepted acknowledge ends the request and yields a seed.
    p_ack_ends_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src_req_o && src_ack_i |=> !src_req_o && seed_valid_o);

    // R6: the seed strobe lasts a single cycle.
    p_seed_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seed_valid_o |=> !seed_valid_o);

    // R5: without masking no new request appears.
    p_no_req_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en_i && !src_req_o |=> !src_req_o);

    // R11: the error pulse lasts one cycle.
    p_err_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |=> !err_pulse_o);

    // R11: the error code holds until acknowledged.
    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code_o != 2'd0) && !err_processed_i |=> err_code_o == $past(err_code_o));

    // R8: no timeout outside external-source mode with masking.
    p_no_timeout_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code_o == 2'd0) && (mode_i != 2'b10 || !mask_en_i) |=> err_code_o != 2'd1);

    // R2: without a completion or clear the count does not move.
    p_cnt_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_en_i && !op_done_i && !sw_clr_i |=> !mask_en_i || hash_cnt_o == $past(hash_cnt_o));
endmodule

bind entropy_refresh_ctrl entropy_refresh_ctrl_checker #(.CNT_W(CNT_W)) u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .mask_en_i       (mask_en_i),
    .mode_i          (mode_i),
    .op_done_i       (op_done_i),
    .sw_clr_i        (sw_clr_i),
    .err_processed_i (err_processed_i),
    .src_req_o       (src_req_o),
    .src_ack_i       (src_ack_i),
    .seed_valid_o    (seed_valid_o),
    .hash_cnt_o      (hash_cnt_o),
    .err_code_o      (err_code_o),
    .err_pulse_o     (err_pulse_o)
);

// File: tb/entropy_refresh_ctrl_bench.sv
module entropy_refresh_ctrl_bench;
    localparam int CNT_W = 8, PRE_W = 8, WAIT_W = 8, DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic mask_en, ready_cfg, op_start, op_done, sw_req, sw_clr, err_proc, ack;
    logic [1:0] mode;
    logic [CNT_W-1:0] thr;
    logic [PRE_W-1:0] pre;
    logic [WAIT_W-1:0] lim;
    logic [DATA_W-1:0] data;
    logic src_req, seed_valid, err_pulse;
    logic [DATA_W-1:0] seed;
    logic [CNT_W-1:0] cnt;
    logic [1:0] err_code;
    int n_chk = 0, n_fail = 0;
    int model;

    always #5 clk = ~clk;

    entropy_refresh_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .WAIT_W(WAIT_W), .DATA_W(DATA_W))
    u_entropy_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .mask_en_i(mask_en), .mode_i(mode),
        .ready_cfg_i(ready_cfg), .threshold_i(thr), .prescale_i(pre),
        .wait_limit_i(lim), .op_start_i(op_start), .op_done_i(op_done),
        .sw_req_i(sw_req), .sw_clr_i(sw_clr), .err_processed_i(err_proc),
        .src_req_o(src_req), .src_ack_i(ack), .src_data_i(data),
        .seed_o(seed), .seed_valid_o(seed_valid), .hash_cnt_o(cnt),
        .err_code_o(err_code), .err_pulse_o(err_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_done();
        op_done = 1'b1; step(); op_done = 1'b0;
    endtask

    task automatic pulse_req();
        sw_req = 1'b1; step(); sw_req = 1'b0;
    endtask

    task automatic do_ack(input logic [DATA_W-1:0] d);
        ack = 1'b1; data = d; step(); ack = 1'b0;
    endtask

    task automatic clear_err();
        err_proc = 1'b1; step(); err_proc = 1'b0;
    endtask

    // Expected count after one edge, from R2/R3/R4/R5.
    function automatic int next_cnt(input int m, input logic mk, input logic dn,
                                    input logic cl, input int t);
        if (!mk || cl) return 0;
        if (!dn) return m;
        if (t != 0 && m + 1 >= t) return 0;
        return (m == 255) ? 255 : m + 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd77));
        rst_n = 1'b0; mask_en = 1'b1; mode = 2'b10; ready_cfg = 1'b1;
        op_start = 0; op_done = 0; sw_req = 0; sw_clr = 0; err_proc = 0; ack = 0;
        thr = 3; pre = 0; lim = 0; data = '0;
        repeat (3) step();
        check("R1 req in reset", src_req, 0);
        check("R1 cnt in reset", cnt, 0);
        check("R1 err in reset", err_code, 0);
        rst_n = 1'b1; step();
        check("R1 seed_valid after reset", seed_valid, 0);
        check("R1 err_pulse after reset", err_pulse, 0);

        // R2 / R3: threshold refresh
        pulse_done(); pulse_done();
        check("R2 count two", cnt, 2);
        check("R3 no req before threshold", src_req, 0);
        pulse_done();
        check("R3 count restarts", cnt, 0);
        check("R3 req on threshold", src_req, 1);
        step();
        check("R6 req holds", src_req, 1);
        do_ack(32'hA5A5_1234);
        check("R6 seed captured", seed, 32'hA5A5_1234);
        check("R6 seed_valid", seed_valid, 1);
        check("R6 req drops", src_req, 0);
        step();
        check("R6 seed_valid one cycle", seed_valid, 0);

        // R4: software request and clear
        pulse_req();
        check("R4 forced req", src_req, 1);
        do_ack(32'h0BAD_F00D);
        thr = 0;
        op_done = 1'b1; repeat (300) step(); op_done = 1'b0;
        check("R2 saturation with zero threshold", cnt, 255);
        check("R2 zero threshold no req", src_req, 0);
        sw_clr = 1'b1; op_done = 1'b1; step(); sw_clr = 1'b0; op_done = 1'b0;
        check("R4 clear beats done", cnt, 0);

        // R5: masking off
        mask_en = 1'b0;
        pulse_done(); pulse_done();
        check("R5 count reads zero", cnt, 0);
        pulse_req();
        check("R5 no req unmasked", src_req, 0);
        mask_en = 1'b1; step();
        check("R5 count held zero", cnt, 0);

        // R7: timeout P=2 L=3 -> request lasts 10 cycles
        pre = 2; lim = 3;
        pulse_req();
        for (int i = 0; i < 10; i++) begin
            check("R7 req during window", src_req, 1);
            check("R7 no err during window", err_code, 0);
            step();
        end
        check("R7 timeout code", err_code, 1);
        check("R7 req dropped", src_req, 0);
        check("R11 err pulse", err_pulse, 1);
        step();
        check("R11 err pulse one cycle", err_pulse, 0);
        pulse_req();
        check("R11 trigger ignored in error", src_req, 0);
        check("R11 code held", err_code, 1);
        clear_err();
        check("R11 code cleared", err_code, 0);

        // R8: mode leaves external-source during wait
        pre = 0; lim = 2;
        pulse_req();
        mode = 2'b01;
        repeat (20) step();
        check("R8 no timeout in sw mode", err_code, 0);
        check("R8 req still open", src_req, 1);
        mask_en = 1'b0;
        mode = 2'b10;
        repeat (20) step();
        check("R8 no timeout unmasked", err_code, 0);
        do_ack(32'h1111_2222);
        mask_en = 1'b1;
        check("R6 ack after gated wait", seed, 32'h1111_2222);

        // R7: zero limit disables timeout
        lim = 0;
        pulse_req();
        repeat (40) step();
        check("R7 zero limit no timeout", err_code, 0);
        do_ack(32'h3);

        // R7: ack just before expiry
        lim = 2;
        pulse_req();
        do_ack(32'h4444);
        check("R7 ack before expiry no err", err_code, 0);
        check("R7 ack before expiry seed", seed_valid, 1);
        step();

        // R9: illegal modes
        mode = 2'b00;
        pulse_req();
        check("R9 illegal mode code", err_code, 2);
        check("R9 no req illegal", src_req, 0);
        clear_err();
        mode = 2'b11; thr = 1;
        pulse_done();
        check("R9 illegal mode on threshold", err_code, 2);
        clear_err();
        mode = 2'b10; thr = 0;

        // R10: ready bit
        ready_cfg = 1'b0;
        op_start = 1'b1; step(); op_start = 1'b0;
        check("R10 missing ready", err_code, 3);
        clear_err();
        mode = 2'b01;
        op_start = 1'b1; step(); op_start = 1'b0;
        check("R10 sw mode no err", err_code, 0);
        mode = 2'b10; mask_en = 1'b0;
        op_start = 1'b1; step(); op_start = 1'b0;
        check("R10 unmasked no err", err_code, 0);
        mask_en = 1'b1; ready_cfg = 1'b1;

        // R12: software mode triggers nothing
        mode = 2'b01;
        pulse_req();
        check("R12 no req sw mode", src_req, 0);
        check("R12 no err sw mode", err_code, 0);

        // Random counter traffic in software mode (R2 R4 R5 R12)
        sw_clr = 1'b1; step(); sw_clr = 1'b0;
        model = 0;
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) thr = CNT_W'($urandom % 8);
            mask_en = ($urandom % 8) != 0;
            op_done = $urandom % 2;
            sw_clr  = ($urandom % 16) == 0;
            sw_req  = ($urandom % 8) == 0;
            step();
            model = next_cnt(model, mask_en, op_done, sw_clr, int'(thr));
            check("R2 random count", cnt, mask_en ? model : 0);
            check("R12 random no req", src_req, 0);
        end
        op_done = 0; sw_clr = 0; sw_req = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule